// File: doc/BRIEF.md
# Dual-Channel Power Mode Sequencer

This controller sets the operating state of a two-channel sampling front end from three control inputs. The first is an active-low full power-down request. The second is a sleep bus with one bit per channel. The third is the sample clock. When power-down is released, a shared reference-settle timer runs. Each channel then either becomes ready or parks in sleep, depending on its sleep bit. A sleeping channel that is requested again runs its own shorter wake-up count before it is declared ready.

While a channel is not ready, its data output is forced to zero. Power-down overrides every other input. Dropping a channel's request while its wake-up count is running cancels the count, and the channel returns to sleep.

Both wake-up latencies are parameters counted in sample clocks. The defaults are 580 cycles for reference settling and 25 cycles for waking from sleep.

Top module: `pwr_mode_seq`

## Requirements
- R1: While pd_ni is low, the first clock edge that samples it sets ref_state_o to 0 and clears ch_active_o, ch_clk_en_o and ch_ready_o. This holds whatever the value of slp_ni, and the outputs stay cleared for as long as pd_ni is low.
- R2: Bit i of slp_ni requests channel i. The value 00 requests neither channel, 01 requests channel 0 only, 10 requests channel 1 only and 11 requests both. Bit i of every per-channel output belongs to channel i.
- R3: ref_state_o is encoded as 0 for off, 1 for settling and 2 for settled. The first edge that samples pd_ni high after power-down moves it to 1. It moves to 2 on the PD_WAKE_CYC-th edge after that, unless pd_ni is low at that edge.
- R4: When the reference becomes settled, each requested channel becomes ready on the same edge. Each channel that is not requested goes to sleep, with active, clock enable and ready all low.
- R5: A sleeping channel whose request is first sampled high at edge E0 sets ch_active_o from E0 onward. It sets ch_ready_o and ch_clk_en_o at edge E0+SLP_WAKE_CYC, and not earlier.
- R6: A ready channel whose request is sampled low clears ch_ready_o, ch_clk_en_o and ch_active_o on that same edge.
- R7: If a channel's request is sampled low while its wake-up count is running, including on the edge where the count would complete, the channel returns to sleep without asserting ready. A later request restarts the full SLP_WAKE_CYC count.
- R8: Each channel's slice of ch_data_o equals its slice of ch_data_i while that channel is ready, and is zero otherwise. This includes power-down. Channel 0 occupies the low DW bits.
- R9: While rst_ni is low, ref_state_o is 0 and all per-channel outputs and ch_data_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Full power-down request, active low |
| slp_ni | input | NCH | Per-channel request, bit high = channel active |
| ch_data_i | input | NCH*DW | Raw conversion data, channel 0 in low bits |
| ref_state_o | output | 2 | Reference state: 0 off, 1 settling, 2 settled |
| ch_active_o | output | NCH | Channel powered (waking or ready) |
| ch_clk_en_o | output | NCH | Channel internal clock enabled |
| ch_ready_o | output | NCH | Channel output valid |
| ch_data_o | output | NCH*DW | Gated data, zero while channel not ready |

## Verification
Two events can fall on the same clock edge. In the first, a channel's request drops on exactly the edge where its wake-up count would expire. In the second, pd_ni drops on exactly the edge where reference settling would complete. The bench provokes the first by lowering the request after precisely SLP_WAKE_CYC-1 counted edges, and the second by lowering pd_ni after PD_WAKE_CYC-1 settling edges. In both cases the drop must win: the channel must stay in sleep with ready low, or the reference must fall back to off with no channel ready. After the power-down case, a new release must take the full settle time again.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    REF_OFF    = 2'd0,
    REF_SETTLE = 2'd1,
    REF_READY  = 2'd2
  } ref_st_e;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_SLEEP = 2'd1,
    CH_WAKE  = 2'd2,
    CH_ON    = 2'd3
  } ch_st_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pwr_ref_timer.sv
module pwr_ref_timer
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 580
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pd_ni,
  output ref_st_e state_o,
  output logic    done_o
);
  localparam int unsigned CW = cnt_w(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  ref_st_e       state_q;
  logic [CW-1:0] cnt_q;

  assign done_o  = pd_ni && (state_q == REF_SETTLE) && (cnt_q == LAST);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= REF_OFF;
      cnt_q   <= '0;
    end else if (!pd_ni) begin
      state_q <= REF_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        REF_OFF: begin
          state_q <= REF_SETTLE;
          cnt_q   <= '0;
        end
        REF_SETTLE: begin
          if (cnt_q == LAST) begin
            state_q <= REF_READY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= REF_READY;
      endcase
    end
  end

  AST_PD_FORCES_REF_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> state_q == REF_OFF); // R1
  AST_SETTLE_AFTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == REF_OFF && pd_ni) |=> state_q == REF_SETTLE); // R3
  AST_REF_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/pwr_chan_fsm.sv
module pwr_chan_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic req_i,
  input  logic ref_done_i,
  output logic active_o,
  output logic clk_en_o,
  output logic ready_o
);
  localparam int unsigned CW = cnt_w(WAKE_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  ch_st_e        st_q;
  logic [CW-1:0] cnt_q;

  assign active_o = (st_q == CH_WAKE) || (st_q == CH_ON);
  assign clk_en_o = (st_q == CH_ON);
  assign ready_o  = (st_q == CH_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_OFF;
      cnt_q <= '0;
    end else if (!pd_ni) begin
      st_q  <= CH_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        CH_OFF: begin
          if (ref_done_i) st_q <= req_i ? CH_ON : CH_SLEEP;
        end
        CH_SLEEP: begin
          cnt_q <= '0;
          if (req_i) st_q <= CH_WAKE;
        end
        CH_WAKE: begin
          // a dropped request wins over count expiry
          if (!req_i) begin
            st_q  <= CH_SLEEP;
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            st_q  <= CH_ON;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (!req_i) st_q <= CH_SLEEP;
        end
      endcase
    end
  end

  AST_PD_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !ready_o && !active_o); // R1
  AST_SLEEP_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o); // R6
  AST_WAKE_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_WAKE && !req_i && pd_ni) |=> st_q == CH_SLEEP); // R7
  AST_NO_SKIP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_SLEEP) |=> st_q != CH_ON); // R5
  AST_WAKE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/pwr_out_gate.sv
module pwr_out_gate #(
  parameter int unsigned DW = 10
) (
  input  logic          ready_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  assign data_o = ready_i ? data_i : '0;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned NCH          = 2,
  parameter int unsigned DW           = 10,
  parameter int unsigned PD_WAKE_CYC  = 580,
  parameter int unsigned SLP_WAKE_CYC = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic [NCH-1:0]    slp_ni,
  input  logic [NCH*DW-1:0] ch_data_i,
  output logic [1:0]        ref_state_o,
  output logic [NCH-1:0]    ch_active_o,
  output logic [NCH-1:0]    ch_clk_en_o,
  output logic [NCH-1:0]    ch_ready_o,
  output logic [NCH*DW-1:0] ch_data_o
);
  ref_st_e ref_st;
  logic    ref_done;

  pwr_ref_timer #(.SETTLE_CYC(PD_WAKE_CYC)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pd_ni   (pd_ni),
    .state_o (ref_st),
    .done_o  (ref_done)
  );

  assign ref_state_o = ref_st;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwr_chan_fsm #(.WAKE_CYC(SLP_WAKE_CYC)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pd_ni      (pd_ni),
      .req_i      (slp_ni[i]),
      .ref_done_i (ref_done),
      .active_o   (ch_active_o[i]),
      .clk_en_o   (ch_clk_en_o[i]),
      .ready_o    (ch_ready_o[i])
    );

    pwr_out_gate #(.DW(DW)) u_gate (
      .ready_i (ch_ready_o[i]),
      .data_i  (ch_data_i[i*DW +: DW]),
      .data_o  (ch_data_o[i*DW +: DW])
    );
  end

  AST_PD_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> ch_data_o == '0); // R8
  AST_PD_NO_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (ch_active_o == '0) && (ch_clk_en_o == '0)); // R1
  AST_READY_NEEDS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ready_o != '0) |-> ref_state_o == 2'd2); // R4
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int NCH = 2;
  localparam int DW  = 10;
  localparam int PDW = 580;
  localparam int SLW = 25;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              pd_ni;
  logic [NCH-1:0]    slp_ni;
  logic [NCH*DW-1:0] ch_data_i;
  logic [1:0]        ref_state_o;
  logic [NCH-1:0]    ch_active_o;
  logic [NCH-1:0]    ch_clk_en_o;
  logic [NCH-1:0]    ch_ready_o;
  logic [NCH*DW-1:0] ch_data_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pwr_mode_seq #(.NCH(NCH), .DW(DW), .PD_WAKE_CYC(PDW), .SLP_WAKE_CYC(SLW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .slp_ni(slp_ni),
    .ch_data_i(ch_data_i), .ref_state_o(ref_state_o), .ch_active_o(ch_active_o),
    .ch_clk_en_o(ch_clk_en_o), .ch_ready_o(ch_ready_o), .ch_data_o(ch_data_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    step(1);
    chk("R9", "ref_state", 32'(ref_state_o), 0);
    chk("R9", "active", 32'(ch_active_o), 0);
    chk("R9", "ready", 32'(ch_ready_o), 0);
    chk("R9", "data", 32'(ch_data_o), 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1", "ref off while pd low", 32'(ref_state_o), 0);
  endtask

  task automatic t_pd_wake();
    slp_ni = 2'b01;
    pd_ni  = 1'b1;
    step(1);
    chk("R3", "settling starts", 32'(ref_state_o), 1);
    step(PDW - 1);
    chk("R3", "still settling", 32'(ref_state_o), 1);
    chk("R4", "not ready before settle", 32'(ch_ready_o), 0);
    step(1);
    chk("R3", "settled", 32'(ref_state_o), 2);
    chk("R4", "ch0 ready at settle", 32'(ch_ready_o), 2'b01);
    chk("R2", "only ch0 active", 32'(ch_active_o), 2'b01);
    chk("R4", "clk_en", 32'(ch_clk_en_o), 2'b01);
    chk("R8", "ch0 data passes", 32'(ch_data_o), 32'({10'h000, 10'h2AA}));
  endtask

  task automatic t_sleep_wake();
    slp_ni = 2'b11;
    step(1);
    chk("R5", "ch1 active during wake", 32'(ch_active_o), 2'b11);
    chk("R5", "ch1 clk off during wake", 32'(ch_clk_en_o), 2'b01);
    step(SLW - 1);
    chk("R5", "ch1 not ready at SLW-1", 32'(ch_ready_o), 2'b01);
    step(1);
    chk("R5", "ch1 ready at SLW", 32'(ch_ready_o), 2'b11);
    chk("R5", "ch1 clk_en", 32'(ch_clk_en_o), 2'b11);
    chk("R8", "both data pass", 32'(ch_data_o), 32'({10'h155, 10'h2AA}));
  endtask

  task automatic t_sleep_entry();
    slp_ni = 2'b10;
    step(1);
    chk("R6", "ch0 ready drops", 32'(ch_ready_o), 2'b10);
    chk("R6", "ch0 active drops", 32'(ch_active_o), 2'b10);
    chk("R6", "ch0 clk_en drops", 32'(ch_clk_en_o), 2'b10);
    chk("R8", "ch0 data zero", 32'(ch_data_o), 32'({10'h155, 10'h000}));
  endtask

  task automatic t_cancel();
    slp_ni = 2'b11;
    step(10);
    slp_ni = 2'b10;
    step(1);
    chk("R7", "cancel active", 32'(ch_active_o), 2'b10);
    step(30);
    chk("R7", "no ready after cancel", 32'(ch_ready_o), 2'b10);
    slp_ni = 2'b11;
    step(SLW);
    chk("R7", "full recount not done", 32'(ch_ready_o), 2'b10);
    step(1);
    chk("R7", "full recount done", 32'(ch_ready_o), 2'b11);
  endtask

  task automatic t_same_cycle();
    slp_ni = 2'b10;
    step(1);
    slp_ni = 2'b11;
    step(SLW);
    chk("R7", "count at last", 32'(ch_ready_o), 2'b10);
    slp_ni = 2'b10;
    step(1);
    chk("R7", "drop wins at expiry ready", 32'(ch_ready_o), 2'b10);
    chk("R7", "drop wins at expiry active", 32'(ch_active_o), 2'b10);
    step(5);
    chk("R7", "stays asleep", 32'(ch_ready_o), 2'b10);
  endtask

  task automatic t_pd_override();
    slp_ni = 2'b11;
    step(SLW + 1);
    chk("R5", "both ready", 32'(ch_ready_o), 2'b11);
    pd_ni = 1'b0;
    step(1);
    chk("R1", "ref off", 32'(ref_state_o), 0);
    chk("R1", "active off", 32'(ch_active_o), 0);
    chk("R1", "clk_en off", 32'(ch_clk_en_o), 0);
    chk("R1", "ready off", 32'(ch_ready_o), 0);
    chk("R8", "data zero in pd", 32'(ch_data_o), 0);
    slp_ni = 2'b01;
    step(5);
    chk("R1", "sleep bus ignored in pd", 32'(ch_active_o), 0);
    chk("R1", "ref stays off", 32'(ref_state_o), 0);
  endtask

  task automatic t_pd_coincide();
    slp_ni = 2'b11;
    pd_ni  = 1'b1;
    step(PDW);
    chk("R3", "settling at last", 32'(ref_state_o), 1);
    pd_ni = 1'b0;
    step(1);
    chk("R1", "pd wins at settle ref", 32'(ref_state_o), 0);
    chk("R1", "pd wins at settle ready", 32'(ch_ready_o), 0);
    pd_ni = 1'b1;
    step(PDW);
    chk("R3", "full resettle pending", 32'(ref_state_o), 1);
    chk("R4", "no ready yet", 32'(ch_ready_o), 0);
    step(1);
    chk("R4", "both ready after resettle", 32'(ch_ready_o), 2'b11);
  endtask

  task automatic t_decode_none();
    pd_ni = 1'b0;
    step(2);
    slp_ni = 2'b00;
    pd_ni  = 1'b1;
    step(PDW + 1);
    chk("R3", "settled", 32'(ref_state_o), 2);
    chk("R2", "00 none ready", 32'(ch_ready_o), 0);
    chk("R4", "00 none active", 32'(ch_active_o), 0);
    slp_ni = 2'b10;
    step(SLW + 1);
    chk("R2", "10 ch1 ready", 32'(ch_ready_o), 2'b10);
    chk("R2", "10 ch1 active", 32'(ch_active_o), 2'b10);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni    = 1'b0;
    pd_ni     = 1'b0;
    slp_ni    = 2'b00;
    ch_data_i = {10'h155, 10'h2AA};
    t_reset();
    t_pd_wake();
    t_sleep_wake();
    t_sleep_entry();
    t_cancel();
    t_same_cycle();
    t_pd_override();
    t_pd_coincide();
    t_decode_none();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule